// File: doc/BRIEF.md
# Serial Control and Status Port for a Triple Half-Bridge Driver

This block is the 16-bit serial slave port of a three-channel half-bridge load driver. A host lowers chip select, clocks a control word in on data-in and, at the same time, reads a status word out on data-out, least significant bit first in both directions. When chip select returns high, the received word becomes the driver's control state: a status-clear request, the six switch enables and the overcurrent-shutdown enable. The status word comes in parallel from the rest of the driver and is captured at the moment chip select falls.

The serial pins are asynchronous to the block's system clock. Each pin passes through a synchronizer, and every pin edge becomes a one-cycle strobe. The serial clock idles low. Data-in is sampled on its falling edge, and data-out moves to the next bit on its rising edge. Data-out has a separate enable, so a pad can tri-state it while chip select is high. After the sixteenth status bit, data-out repeats the bits that arrived on data-in sixteen clocks earlier, so the ports of several devices can be chained. A frame applies only if it had exactly sixteen falling clock edges. An early chip-select rise, used to read just the prewarning bit, leaves every register as it was.

Top module: `hb_serial_port`

## Requirements
- R1: After reset the overcurrent-shutdown enable is 1, the six switch enables and the status-clear bit are 0, and the data-out enable is 0.
- R2: While chip select is high, the data-out enable is 0 and data-out is 0. Both stay that way however the serial clock moves. The enable goes to 1 after chip select falls.
- R3: The status word is captured when chip select falls, and its bit 0 (the temperature prewarning) is on data-out before the first serial clock edge.
- R4: Each rising serial-clock edge moves data-out to the next status bit, bit 1 through bit 15 in order. Data-out holds its value between rising edges.
- R5: Rising edges 16 and later put on data-out the data-in bits sampled at falling edges 1, 2, ... in that order, so the output trails the input by 16 bits.
- R6: Data-in is sampled at each falling serial-clock edge, and the first sample is word bit 0. When chip select rises after exactly 16 falling edges, the word is applied as follows: bit 0 goes to the status-clear output; bits 1..6 go to switch enables 0..5 (LS1, HS1, LS2, HS2, LS3, HS3); bit 13 goes to the overcurrent-shutdown enable. All other bits are ignored.
- R7: A frame with fewer than 16 falling edges, including none, leaves the control outputs unchanged.
- R8: A frame with more than 16 falling edges leaves the control outputs unchanged.
- R9: Serial clock and data-in activity while chip select is high changes neither data-out nor the control outputs.
- R10: A change of the parallel status input after chip select has fallen does not change the bits shifted out in that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Chip select, active low, asynchronous |
| sclk | input | 1 | Serial clock, idles low, asynchronous |
| sdi | input | 1 | Serial data in |
| statusIn | input | 16 | Parallel status word: bit 0 prewarning, bits 1..6 switch states, bit 13 short circuit, bit 14 open load, bit 15 supply fail |
| statRst | output | 1 | Latched status-clear request |
| switchEn | output | 6 | Latched switch enables LS1, HS1, LS2, HS2, LS3, HS3 |
| ocEn | output | 1 | Latched overcurrent-shutdown enable |
| sdo | output | 1 | Serial data out, 0 when not enabled |
| sdoEn | output | 1 | Data-out driver enable |

## Verification
The assertions assume that each level of chip select, serial clock and data-in lasts at least one cycle longer than the synchronizer depth. Under that condition, no two pin edges collapse into one sampled step, and a clock edge never coincides with a chip-select edge. They also assume the serial clock is low whenever chip select changes. The stimulus holds every pin level for five system clocks, and it changes the serial clock only while chip select is steady. Data-in changes only together with a rising serial-clock edge, so it is stable around every falling edge.

// File: rtl/hbsp_pkg.sv
package hbsp_pkg;
  localparam int WORD_BITS   = 16;
  localparam int SWITCHES    = 6;
  localparam int POS_CLEAR   = 0;
  localparam int POS_SWITCH0 = 1;
  localparam int POS_OCEN    = 13;

  typedef struct packed {
    logic load;     // chip select fell: capture status, enable output
    logic shift;    // serial clock fell while selected: take one data-in bit
    logic advance;  // serial clock rose while selected: next bit to data-out
    logic drop;     // chip select rose: disable output
    logic commit;   // chip select rose after exactly one full word
  } strobe_t;
endpackage

// File: rtl/hbsp_ctrl.sv
module hbsp_ctrl
  import hbsp_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int WORD        = WORD_BITS
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    csN,
  input  logic    sclk,
  input  logic    sdi,
  output strobe_t strb,
  output logic    sdiSync
);
  localparam int CNT_W   = $clog2(WORD + 2);
  localparam int CNT_TOP = WORD + 1;

  logic [SYNC_STAGES-1:0] csPipe, sclkPipe, sdiPipe;

  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          csPipe[g]   <= 1'b1;
          sclkPipe[g] <= 1'b0;
          sdiPipe[g]  <= 1'b0;
        end else begin
          csPipe[g]   <= csN;
          sclkPipe[g] <= sclk;
          sdiPipe[g]  <= sdi;
        end
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          csPipe[g]   <= 1'b1;
          sclkPipe[g] <= 1'b0;
          sdiPipe[g]  <= 1'b0;
        end else begin
          csPipe[g]   <= csPipe[g-1];
          sclkPipe[g] <= sclkPipe[g-1];
          sdiPipe[g]  <= sdiPipe[g-1];
        end
      end
    end
  end

  logic csNow, sclkNow, csPrev, sclkPrev, selected;
  logic [CNT_W-1:0] bitCount;

  assign csNow   = csPipe[SYNC_STAGES-1];
  assign sclkNow = sclkPipe[SYNC_STAGES-1];
  assign sdiSync = sdiPipe[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csPrev   <= 1'b1;
      sclkPrev <= 1'b0;
    end else begin
      csPrev   <= csNow;
      sclkPrev <= sclkNow;
    end
  end

  assign selected = !csNow && !csPrev;

  always_comb begin
    strb.load    = csPrev && !csNow;
    strb.drop    = !csPrev && csNow;
    strb.shift   = selected && sclkPrev && !sclkNow;
    strb.advance = selected && !sclkPrev && sclkNow;
    strb.commit  = strb.drop && (bitCount == CNT_W'(WORD));
  end

  // Falling edges since chip select fell, saturating one past a full word
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCount <= '0;
    end else if (strb.load) begin
      bitCount <= '0;
    end else if (strb.shift && bitCount != CNT_W'(CNT_TOP)) begin
      bitCount <= bitCount + 1'b1;
    end
  end

  // R8
  count_bounded_chk: assert property (@(posedge clk) disable iff (!rstN)
    bitCount <= CNT_W'(CNT_TOP));

  // R9
  strobe_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.load, strb.shift, strb.advance, strb.drop}));

  // R6
  shift_counts_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.shift |=> bitCount != '0);
endmodule

// File: rtl/hbsp_datapath.sv
module hbsp_datapath
  import hbsp_pkg::*;
#(
  parameter int WORD = WORD_BITS,
  parameter int SW   = SWITCHES
) (
  input  logic            clk,
  input  logic            rstN,
  input  strobe_t         strb,
  input  logic            sdiSync,
  input  logic [WORD-1:0] statusIn,
  output logic            statRst,
  output logic [SW-1:0]   switchEn,
  output logic            ocEn,
  output logic            sdo,
  output logic            sdoEn
);
  logic [WORD-1:0] shiftReg;
  logic            outBit;

  // Status in at chip-select fall; data-in enters at the top on each fall
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
    end else if (strb.load) begin
      shiftReg <= statusIn;
    end else if (strb.shift) begin
      shiftReg <= {sdiSync, shiftReg[WORD-1:1]};
    end
  end

  // Rising edge k presents bit k of the stream: status bits, then data-in
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outBit <= 1'b0;
      sdoEn  <= 1'b0;
    end else begin
      if (strb.load) begin
        outBit <= statusIn[0];
        sdoEn  <= 1'b1;
      end else if (strb.advance) begin
        outBit <= shiftReg[1];
      end
      if (strb.drop) sdoEn <= 1'b0;
    end
  end

  assign sdo = outBit && sdoEn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statRst  <= 1'b0;
      switchEn <= '0;
      ocEn     <= 1'b1;
    end else if (strb.commit) begin
      statRst  <= shiftReg[POS_CLEAR];
      switchEn <= shiftReg[POS_SWITCH0 +: SW];
      ocEn     <= shiftReg[POS_OCEN];
    end
  end

  // R3
  first_bit_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> sdoEn && (sdo == $past(statusIn[0])));

  // R2
  output_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.drop |=> !sdoEn && !sdo);

  // R4
  sdo_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sdoEn && !strb.load && !strb.advance && !strb.drop) |=> $stable(sdo));

  // R7
  control_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.commit |=> $stable({statRst, switchEn, ocEn}));
endmodule

// File: rtl/hb_serial_port.sv
module hb_serial_port
  import hbsp_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 csN,
  input  logic                 sclk,
  input  logic                 sdi,
  input  logic [WORD_BITS-1:0] statusIn,
  output logic                 statRst,
  output logic [SWITCHES-1:0]  switchEn,
  output logic                 ocEn,
  output logic                 sdo,
  output logic                 sdoEn
);
  strobe_t strb;
  logic    sdiSync;

  hbsp_ctrl #(
    .SYNC_STAGES(SYNC_STAGES),
    .WORD       (WORD_BITS)
  ) uCtrl (
    .clk    (clk),
    .rstN   (rstN),
    .csN    (csN),
    .sclk   (sclk),
    .sdi    (sdi),
    .strb   (strb),
    .sdiSync(sdiSync)
  );

  hbsp_datapath #(
    .WORD(WORD_BITS),
    .SW  (SWITCHES)
  ) uData (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .sdiSync (sdiSync),
    .statusIn(statusIn),
    .statRst (statRst),
    .switchEn(switchEn),
    .ocEn    (ocEn),
    .sdo     (sdo),
    .sdoEn   (sdoEn)
  );
endmodule

// File: tb/hb_serial_port_test.sv
`timescale 1ns/1ps
module hb_serial_port_test;
  localparam int SYNC = 2;
  localparam int HOLD = 5;
  localparam int LIMIT = 100000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b1, sclk = 1'b0, sdi = 1'b0;
  logic [15:0] statusIn = '0;
  logic statRst, ocEn, sdo, sdoEn;
  logic [5:0] switchEn;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  hb_serial_port #(.SYNC_STAGES(SYNC)) uut (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .sdi(sdi),
    .statusIn(statusIn), .statRst(statRst), .switchEn(switchEn),
    .ocEn(ocEn), .sdo(sdo), .sdoEn(sdoEn)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [2:0] pinHist[$];      // {cs, sclk, sdi} per clock edge
  bit         mEn, mSdo;
  logic [15:0] mStat;
  bit         mRx[$];
  int         mFalls, mRises;
  logic [7:0] mCtrl;           // {ocEn, switchEn[5:0], statRst}

  always @(posedge clk) begin
    logic [2:0] cur, prev;
    bit csF, csR, sel, sF, sR;
    if (!rstN) begin
      pinHist.delete();
      for (int i = 0; i < SYNC + 1; i++) pinHist.push_back(3'b100);
      mEn = 0; mSdo = 0; mStat = '0; mRx.delete();
      mFalls = 0; mRises = 0; mCtrl = 8'h80;
    end else begin
      pinHist.push_back({csN, sclk, sdi});
      cur  = pinHist[pinHist.size() - 1 - SYNC];
      prev = pinHist[pinHist.size() - 2 - SYNC];
      csF = prev[2] && !cur[2];
      csR = !prev[2] && cur[2];
      sel = !prev[2] && !cur[2];
      sF  = sel && prev[1] && !cur[1];
      sR  = sel && !prev[1] && cur[1];
      if (csF) begin
        mEn = 1; mStat = statusIn; mSdo = statusIn[0];
        mRx.delete(); mFalls = 0; mRises = 0;
      end
      if (sF) begin
        mRx.push_back(cur[0]);
        mFalls++;
      end
      if (sR) begin
        mRises++;
        mSdo = (mRises < 16) ? mStat[mRises] : mRx[mRises - 16];
      end
      if (csR) begin
        mEn = 0;
        if (mFalls == 16) begin
          mCtrl[0] = mRx[0];
          for (int i = 0; i < 6; i++) mCtrl[i+1] = mRx[i+1];
          mCtrl[7] = mRx[13];
        end
      end
      if (pinHist.size() > SYNC + 2) void'(pinHist.pop_front());
    end
  end

  // Compare against the model on every clock, away from the active edge
  always @(negedge clk) begin
    if (rstN) begin
      check("R2 model sdoEn", sdoEn, mEn);
      check("R4/R5 model sdo", sdo, mEn ? mSdo : 1'b0);
      check("R6 model control", {ocEn, switchEn, statRst}, mCtrl);
    end
  end

  // ---------------- watchdog ----------------
  always @(posedge clk) begin
    cycles++;
    if (cycles > LIMIT) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected<=%0d cycles", cycles, LIMIT);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  // ---------------- host-side stimulus ----------------
  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic frame(input logic [31:0] stream, input int nclk,
                       input logic [15:0] stat, input logic [15:0] statLate,
                       input bit swapMid, output logic [32:0] rx);
    rx = '0;
    statusIn = stat;
    csN = 1'b0;
    waitCyc(HOLD);
    rx[0] = sdo;
    if (swapMid) statusIn = statLate;
    for (int k = 1; k <= nclk; k++) begin
      sclk = 1'b1;
      sdi  = stream[k-1];
      waitCyc(HOLD);
      rx[k] = sdo;
      sclk = 1'b0;
      waitCyc(HOLD);
    end
    csN = 1'b1;
    waitCyc(HOLD);
  endtask

  initial begin
    logic [32:0] rx;
    logic [7:0]  held;
    waitCyc(3);
    rstN = 1'b1;
    waitCyc(2);

    // R1: reset state
    check("R1 reset control", {ocEn, switchEn, statRst}, 8'h80);
    check("R1 reset sdoEn", sdoEn, 1'b0);

    // R6, R3, R4: full write with status readback
    frame(32'h0000_207E, 16, 16'hA5C3, 16'h0, 0, rx);
    check("R3 prewarning bit", rx[0], 1'b1);
    check("R4 status stream", rx[15:0], 16'hA5C3);
    check("R6 switch enables", switchEn, 6'h3F);
    check("R6 oc enable", ocEn, 1'b1);
    check("R6 status clear", statRst, 1'b0);

    // R6: second pattern, ocEn cleared, status-clear set
    frame(32'h0000_0015, 16, 16'h3C5A, 16'h0, 0, rx);
    check("R4 status stream 2", rx[15:0], 16'h3C5A);
    check("R6 control pattern 2", {ocEn, switchEn, statRst}, 8'b0_001010_1);

    // R7: short frame of 8 clocks is discarded
    held = {ocEn, switchEn, statRst};
    frame(32'h0000_207E, 8, 16'h0F0F, 16'h0, 0, rx);
    check("R7 short frame ignored", {ocEn, switchEn, statRst}, held);

    // R3, R7: prewarning-only read with no clocks
    frame(32'h0, 0, 16'h0001, 16'h0, 0, rx);
    check("R3 prewarning only read", rx[0], 1'b1);
    check("R7 aborted frame ignored", {ocEn, switchEn, statRst}, held);

    // R5, R8: 32 clocks, data-in reappears 16 bits later, word discarded
    frame(32'hBEEF_207E, 32, 16'h5AA5, 16'h0, 0, rx);
    check("R4 status before chain", rx[15:0], 16'h5AA5);
    check("R5 chained data", rx[31:16], 16'h207E);
    check("R8 long frame ignored", {ocEn, switchEn, statRst}, held);

    // R9: serial activity with chip select high
    for (int k = 0; k < 10; k++) begin
      sclk = 1'b1; sdi = k[0];
      waitCyc(HOLD);
      check("R9 sdoEn idle", sdoEn, 1'b0);
      check("R2 sdo idle", sdo, 1'b0);
      sclk = 1'b0;
      waitCyc(HOLD);
    end
    sdi = 1'b0;
    check("R9 control untouched", {ocEn, switchEn, statRst}, held);

    // R10: status input changes after chip select fell
    frame(32'h0000_2002, 16, 16'h1234, 16'hEDCB, 1, rx);
    check("R10 captured status", rx[15:0], 16'h1234);
    check("R6 control pattern 3", {ocEn, switchEn, statRst}, 8'b1_000001_0);

    waitCyc(4);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule